// File: doc/BRIEF.md
# Posted Write Buffer with Split Command and Data Queues

This block sits between an upstream slave port that receives bus writes and a downstream master port that replays them. Each write is posted as two parts. The payload words go into a large data queue, one 32-bit word per beat. The address, the beat count and the byte enables go into a small command queue as one entry per transaction. The two queues are sized independently. The upstream side sees the buffer as full as soon as either queue has no free slot.

On the drain side the head command is presented together with its data beats, one beat per handshake. The final beat of a transaction is flagged. The command entry retires on that final beat. Writes leave in the order they arrived. They are never merged or split, so each transaction drains with exactly the words that were posted for it.

The upstream agent must post all data beats of a transaction before it pushes the transaction's command. As a result, a command at the head always has its data waiting.

Top module: `posted_wr_buf`

## Requirements
- R1: After reset both queues are empty: `out_valid_o` is 0, `full_o` is 0, and both `in_cmd_ready_o` and `in_dat_ready_o` are 1.
- R2: Commands drain in the order they were accepted. `out_addr_o`, `out_len_o` and `out_be_o` carry the head command's accepted values unchanged, and they are held stable while `out_ready_i` is low.
- R3: A command with length field L (number of beats minus one) drains in exactly L+1 handshakes. The data words appear in posting order, and `out_last_o` is 1 only on the (L+1)-th beat. After that beat the next command becomes the head.
- R4: The command queue holds six entries. With six entries stored, `in_cmd_ready_o` is 0, and a further command push is ignored and never drains.
- R5: The data queue holds 1024 words (4096 bytes). With 1024 words stored, `in_dat_ready_o` is 0, and a further data push is ignored and never drains.
- R6: `full_o` is 1 exactly when the command queue is full or the data queue is full, whichever of the two it is.
- R7: A push and a drain in the same cycle leave the occupancy of each queue unchanged. The freed and the taken slot are both accounted for.
- R8: `out_valid_o` is 0 while the command queue is empty, and also while a command is queued but no data word is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_dat_valid_i | input | 1 | Upstream data beat valid |
| in_dat_i | input | 32 | Upstream data word |
| in_dat_ready_o | output | 1 | Data queue can accept a word |
| in_cmd_valid_i | input | 1 | Upstream command valid |
| in_cmd_addr_i | input | 32 | Command start address |
| in_cmd_len_i | input | 10 | Beats minus one |
| in_cmd_be_i | input | 4 | Byte enables for the transaction |
| in_cmd_ready_o | output | 1 | Command queue can accept an entry |
| full_o | output | 1 | Either queue full |
| out_valid_o | output | 1 | A drain beat is presented |
| out_ready_i | input | 1 | Downstream takes the beat |
| out_addr_o | output | 32 | Head command address |
| out_len_o | output | 10 | Head command beats minus one |
| out_be_o | output | 4 | Head command byte enables |
| out_data_o | output | 32 | Current data word |
| out_last_o | output | 1 | Final beat of the head command |

## Verification
A wrong occupancy count shows up at the ports only at the boundaries. A ready output drops one push early or late, or a dropped or duplicated entry appears when the queue is drained. For this reason the bench fills each queue to its exact limit and then drains it to empty. A misplaced beat counter shows at once on the next drain: `out_last_o` lands on the wrong beat, and the following command inherits or loses words. The data pattern and the per-beat last flag expose this within one transaction.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
  localparam int unsigned PWB_ADDR_W     = 32;
  localparam int unsigned PWB_DATA_W     = 32;
  localparam int unsigned PWB_BE_W       = PWB_DATA_W / 8;
  localparam int unsigned PWB_DATA_BYTES = 4096;
  localparam int unsigned PWB_DATA_DEPTH = PWB_DATA_BYTES / PWB_BE_W;
  localparam int unsigned PWB_LEN_W      = $clog2(PWB_DATA_DEPTH);

  typedef struct packed {
    logic [PWB_ADDR_W-1:0] addr;
    logic [PWB_LEN_W-1:0]  len;   // beats - 1
    logic [PWB_BE_W-1:0]   be;
  } pwb_cmd_t;
endpackage

// File: rtl/pwb_fifo.sv
`timescale 1ns/1ps
module pwb_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rd_ptr_q];

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wrap_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= wrap_inc(rd_ptr_q);
      unique case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;  // idle or push+pop
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= wdata_i;
  end

  // R4/R5: occupancy never passes the configured depth
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  // R6: a full queue stays full and unchanged until something drains
  p_full_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i |=> full_o && $stable(wr_ptr_q));

  // R8: the drain logic never pops an empty queue
  p_pop_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pwb_drain.sv
`timescale 1ns/1ps
module pwb_drain #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_empty_i,
  input  logic             dat_empty_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic             out_last_o,
  output logic             cmd_pop_o,
  output logic             dat_pop_o
);
  logic [LEN_W-1:0] beat_q;
  logic             xfer;

  assign out_valid_o = !cmd_empty_i && !dat_empty_i;
  assign out_last_o  = out_valid_o && (beat_q == cmd_len_i);
  assign xfer        = out_valid_o && out_ready_i;
  assign dat_pop_o   = xfer;
  assign cmd_pop_o   = xfer && out_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            beat_q <= '0;
    else if (cmd_pop_o)     beat_q <= '0;
    else if (xfer)          beat_q <= beat_q + 1'b1;
  end

  // R3: beat index stays within the head command's length
  p_beat_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_empty_i |-> beat_q <= cmd_len_i);

  // R3: no partial transaction is left behind once commands run out
  p_idle_beat_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_empty_i |-> beat_q == '0);
endmodule

// File: rtl/posted_wr_buf.sv
`timescale 1ns/1ps
module posted_wr_buf
  import pwb_pkg::*;
#(
  parameter int unsigned CMD_DEPTH  = 6,
  parameter int unsigned DATA_BYTES = PWB_DATA_BYTES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_dat_valid_i,
  input  logic [PWB_DATA_W-1:0] in_dat_i,
  output logic                  in_dat_ready_o,
  input  logic                  in_cmd_valid_i,
  input  logic [PWB_ADDR_W-1:0] in_cmd_addr_i,
  input  logic [PWB_LEN_W-1:0]  in_cmd_len_i,
  input  logic [PWB_BE_W-1:0]   in_cmd_be_i,
  output logic                  in_cmd_ready_o,
  output logic                  full_o,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [PWB_ADDR_W-1:0] out_addr_o,
  output logic [PWB_LEN_W-1:0]  out_len_o,
  output logic [PWB_BE_W-1:0]   out_be_o,
  output logic [PWB_DATA_W-1:0] out_data_o,
  output logic                  out_last_o
);
  localparam int unsigned DATA_DEPTH = DATA_BYTES / PWB_BE_W;
  localparam int unsigned CMD_W      = $bits(pwb_cmd_t);

  pwb_cmd_t cmd_in, cmd_head;
  logic     cmd_full, cmd_empty, dat_full, dat_empty;
  logic     cmd_pop, dat_pop;

  assign cmd_in = '{addr: in_cmd_addr_i, len: in_cmd_len_i, be: in_cmd_be_i};

  pwb_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_cmd_valid_i),
    .wdata_i (cmd_in),
    .pop_i   (cmd_pop),
    .rdata_o (cmd_head),
    .full_o  (cmd_full),
    .empty_o (cmd_empty)
  );

  pwb_fifo #(.WIDTH(PWB_DATA_W), .DEPTH(DATA_DEPTH)) u_dat_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_dat_valid_i),
    .wdata_i (in_dat_i),
    .pop_i   (dat_pop),
    .rdata_o (out_data_o),
    .full_o  (dat_full),
    .empty_o (dat_empty)
  );

  pwb_drain #(.LEN_W(PWB_LEN_W)) u_drain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_empty_i (cmd_empty),
    .dat_empty_i (dat_empty),
    .cmd_len_i   (cmd_head.len),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .cmd_pop_o   (cmd_pop),
    .dat_pop_o   (dat_pop)
  );

  assign in_cmd_ready_o = !cmd_full;
  assign in_dat_ready_o = !dat_full;
  assign full_o         = cmd_full || dat_full;
  assign out_addr_o     = cmd_head.addr;
  assign out_len_o      = cmd_head.len;
  assign out_be_o       = cmd_head.be;

  // R2: a stalled beat keeps its command and data
  p_head_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o)
      && $stable(out_be_o) && $stable(out_data_o));

  // R6: full never drops while nothing drains
  p_full_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !(out_valid_o && out_ready_i) |=> full_o);
endmodule

// File: tb/posted_wr_buf_tb.sv
`timescale 1ns/1ps
module posted_wr_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_dat_valid_i = 0, in_cmd_valid_i = 0, out_ready_i = 0;
  logic [31:0] in_dat_i = '0, in_cmd_addr_i = '0;
  logic [9:0]  in_cmd_len_i = '0;
  logic [3:0]  in_cmd_be_i = '0;
  logic        in_dat_ready_o, in_cmd_ready_o, full_o, out_valid_o, out_last_o;
  logic [31:0] out_addr_o, out_data_o;
  logic [9:0]  out_len_o;
  logic [3:0]  out_be_o;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  posted_wr_buf dut_i (.*, .clk_i(clk));

  // {addr, len, be, seed}
  localparam logic [77:0] VECS [5] = '{
    {32'h0000_1000, 10'd0,  4'b0001, 32'hA000_0000},
    {32'h0000_2004, 10'd3,  4'b1111, 32'hB100_0000},
    {32'h0000_3000, 10'd15, 4'b1111, 32'hC200_0000},
    {32'h0000_4001, 10'd0,  4'b0110, 32'hD300_0000},
    {32'hFFFF_FFFC, 10'd0,  4'b1000, 32'hE400_0000}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_dat_valid_i = 0; in_cmd_valid_i = 0; out_ready_i = 0;
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic push_beat(input logic [31:0] d);
    in_dat_valid_i = 1; in_dat_i = d;
    @(negedge clk);
    in_dat_valid_i = 0;
  endtask

  task automatic push_cmd(input logic [31:0] a, input logic [9:0] l, input logic [3:0] b);
    in_cmd_valid_i = 1; in_cmd_addr_i = a; in_cmd_len_i = l; in_cmd_be_i = b;
    @(negedge clk);
    in_cmd_valid_i = 0;
  endtask

  // drains one command; words expected seed ^ beat index
  task automatic drain(input logic [31:0] a, input logic [9:0] l, input logic [3:0] b,
                       input logic [31:0] seed, input string req);
    for (int i = 0; i <= int'(l); i++) begin
      chk(out_valid_o, {req, " valid"}, 64'(out_valid_o), 64'd1);
      chk(out_addr_o == a && out_len_o == l && out_be_o == b, {req, " R2 cmd fields"},
          {out_addr_o, 18'(out_len_o), 14'(out_be_o)}, {a, 18'(l), 14'(b)});
      chk(out_data_o == (seed ^ 32'(i)), {req, " R3 data"}, 64'(out_data_o), 64'(seed ^ 32'(i)));
      chk(out_last_o == (i == int'(l)), {req, " R3 last"}, 64'(out_last_o), 64'(i == int'(l)));
      out_ready_i = 1;
      @(negedge clk);
      out_ready_i = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(!out_valid_o && !full_o && in_cmd_ready_o && in_dat_ready_o, "R1 reset",
        {out_valid_o, full_o, in_cmd_ready_o, in_dat_ready_o}, 4'b0011);

    // vector table: post all, then drain in order (R2, R3)
    for (int v = 0; v < 5; v++) begin
      for (int i = 0; i <= int'(VECS[v][45:36]); i++) push_beat(VECS[v][31:0] ^ 32'(i));
      push_cmd(VECS[v][77:46], VECS[v][45:36], VECS[v][35:32]);
    end
    for (int v = 0; v < 5; v++) begin
      // R2 stall: hold head one cycle with ready low
      @(negedge clk);
      drain(VECS[v][77:46], VECS[v][45:36], VECS[v][35:32], VECS[v][31:0], "R2/R3 vec");
    end
    chk(!out_valid_o, "R8 empty after drain", 64'(out_valid_o), 64'd0);

    // R8: command without data is not presented
    do_reset();
    push_cmd(32'h0000_0500, 10'd0, 4'hF);
    chk(!out_valid_o, "R8 cmd without data", 64'(out_valid_o), 64'd0);
    push_beat(32'h5555_0000);
    drain(32'h0000_0500, 10'd0, 4'hF, 32'h5555_0000, "R8 late data");

    // R4 / R6: command queue full
    do_reset();
    for (int k = 0; k < 6; k++) begin
      push_beat(32'h2000_0000 + 32'(k));
      push_cmd(32'h100 + 32'(k), 10'd0, 4'hF);
    end
    chk(!in_cmd_ready_o && in_dat_ready_o, "R4 cmd ready low at six",
        {in_cmd_ready_o, in_dat_ready_o}, 2'b01);
    chk(full_o, "R6 full from cmd queue", 64'(full_o), 64'd1);
    push_cmd(32'hBAD0_0000, 10'd0, 4'hF);  // must be ignored
    for (int k = 0; k < 6; k++)
      drain(32'h100 + 32'(k), 10'd0, 4'hF, 32'h2000_0000 + 32'(k), "R4 drain");
    chk(!out_valid_o && !full_o, "R4 seventh cmd dropped", {out_valid_o, full_o}, 2'b00);

    // R5 / R6: data queue full at 1024 words
    do_reset();
    for (int k = 0; k < 1024; k++) push_beat(32'h7000_0000 ^ 32'(k));
    chk(!in_dat_ready_o && in_cmd_ready_o, "R5 dat ready low at 1024",
        {in_dat_ready_o, in_cmd_ready_o}, 2'b01);
    chk(full_o, "R6 full from data queue", 64'(full_o), 64'd1);
    push_beat(32'hDEAD_BEEF);  // must be ignored
    push_cmd(32'h0000_8000, 10'd1023, 4'hF);
    drain(32'h0000_8000, 10'd1023, 4'hF, 32'h7000_0000, "R5 drain");
    chk(!out_valid_o && !full_o, "R5 extra beat dropped", {out_valid_o, full_o}, 2'b00);

    // R7: simultaneous push and drain keep occupancy
    do_reset();
    for (int k = 0; k < 5; k++) begin
      push_beat(32'h3000_0000 + 32'(k));
      push_cmd(32'h10 + 32'(k), 10'd0, 4'h3);
    end
    in_dat_valid_i = 1; in_dat_i = 32'h3000_0100;
    in_cmd_valid_i = 1; in_cmd_addr_i = 32'h500; in_cmd_len_i = 0; in_cmd_be_i = 4'h3;
    out_ready_i = 1;
    @(negedge clk);
    in_dat_valid_i = 0; in_cmd_valid_i = 0; out_ready_i = 0;
    chk(in_cmd_ready_o && !full_o, "R7 still room for one",
        {in_cmd_ready_o, full_o}, 2'b10);
    push_beat(32'h3000_0101);
    push_cmd(32'h600, 10'd0, 4'h3);
    chk(!in_cmd_ready_o && full_o, "R7 full after one more",
        {in_cmd_ready_o, full_o}, 2'b01);
    for (int k = 1; k < 5; k++)
      drain(32'h10 + 32'(k), 10'd0, 4'h3, 32'h3000_0000 + 32'(k), "R7 drain");
    drain(32'h500, 10'd0, 4'h3, 32'h3000_0100, "R7 drain");
    drain(32'h600, 10'd0, 4'h3, 32'h3000_0101, "R7 drain");
    chk(!out_valid_o, "R7 empty at end", 64'(out_valid_o), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule